// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block runs a complete read from a serial NOR flash over a four-wire SPI link in mode 0. A single `start` pulse carries a byte address and a byte count. The block lowers chip select and shifts out a 32-bit command word. The read opcode sits in the top byte of that word and the 24-bit address fills the rest. Once the last command bit has left the shifter, the block clocks in the requested bytes and hands them out one beat at a time on `rd_data` / `rd_valid`. When the last beat has been delivered, it raises chip select and pulses `done`.

Long reads are cut into chunks of at most `CHUNK_MAX` bytes. `CHUNK_MAX` defaults to 65532, which is a multiple of four just below a 16-bit transfer counter limit. Between two chunks the serial clock pauses for `GAP_CYC` cycles while chip select stays low, so the flash sees one unbroken read. The beat width is fixed once per read. Four bytes per beat are used when the count is a multiple of four, and one byte per beat otherwise. An address at or above 2^24 is refused at once: `err` and `done` pulse together and no bus activity occurs.

The state machine has seven states:

- `ST_IDLE`: waits for `start`. On a good request it moves to `ST_CMD_GO`. A bad address pulses `err` and `done` and the block stays in `ST_IDLE`.
- `ST_CMD_GO` → `ST_CMD_WAIT`: launches the command word.
- `ST_CMD_WAIT`: waits for the shifter to finish. It goes to `ST_FINISH` if the count is zero, otherwise to `ST_DATA_GO`.
- `ST_DATA_GO` → `ST_DATA_WAIT`: launches one beat.
- `ST_DATA_WAIT`: on each finished beat it goes to `ST_FINISH` after the final beat, to `ST_GAP` at the end of a chunk, and back to `ST_DATA_GO` otherwise.
- `ST_GAP`: holds for `GAP_CYC` cycles, then moves to `ST_DATA_GO`.
- `ST_FINISH` → `ST_IDLE`: releases chip select and pulses `done`.

Top module: `spi_flash_rd`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, and `done`, `err` and `rd_valid` are 0. `spi_sclk` never goes high while `spi_cs_n` is 1.
- R2: Each accepted read first shifts out the 32-bit word {8'h03, addr[23:0]}, most significant bit first. `spi_mosi` changes while `spi_sclk` is low, and the flash samples it on the rising edge.
- R3: A `start` with any of `addr[31:24]` set produces one cycle where `err` and `done` are both 1, and `spi_cs_n` never falls for that request.
- R4: No data bit is clocked until all 32 command bits are out. A read of N bytes produces exactly 32 + 8·N rising edges of `spi_sclk`.
- R5: When `len` is a nonzero multiple of 4, `rd_wide` is 1 and there are `len`/4 beats. In each beat the byte received first sits in bits 31:24 and the byte received last sits in bits 7:0.
- R6: When `len` is not a multiple of 4, `rd_wide` is 0 and there are `len` beats. Each beat carries one byte in bits 7:0 with bits 31:8 at zero.
- R7: Data is read in chunks of `CHUNK_MAX` bytes, the last one possibly shorter. Between chunks `spi_sclk` stays low for at least `GAP_CYC` cycles. No such pause follows the final chunk, even when `len` is an exact multiple of `CHUNK_MAX`.
- R8: `spi_cs_n` falls once per accepted read and rises once, in the same cycle that `done` goes high.
- R9: With `len` = 0 the command word is still sent, no beat is produced, and `done` follows.
- R10: A `start` pulse while a read is in progress is ignored: the running read completes unchanged and no second command is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse |
| addr | input | 32 | Byte address of the first byte to read |
| len | input | LEN_W | Number of bytes to read |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_data | output | 32 | Read beat, packed as given in R5/R6 |
| rd_valid | output | 1 | `rd_data` holds a new beat this cycle |
| rd_wide | output | 1 | 1 when the current read uses four-byte beats |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | One-cycle pulse when the address is refused |

## Verification
The sensitive coincidence is a beat that closes a chunk and the whole read in the same cycle. The block must then go straight to release instead of inserting a chunk pause. The bench provokes this with a length that is an exact multiple of a small `CHUNK_MAX`. It judges the result by counting long low stretches of `spi_sclk` between rising edges while chip select is low: one fewer than the chunk count is expected. A second overlap is a new `start` arriving in mid-read. This is judged from the single command word the flash model captures, the single chip-select fall and the beat count of the original request.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam logic [7:0] RD_OPCODE  = 8'h03;
    localparam int         ADDR_BITS  = 24;
    localparam int         BEAT_BITS  = 32;
    localparam int         BYTE_BITS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_GO,
        ST_CMD_WAIT,
        ST_DATA_GO,
        ST_DATA_WAIT,
        ST_GAP,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/spi_rd_shift.sv
// Mode-0 bit engine: one launch moves either a full word or one byte.
module spi_rd_shift #(
    parameter int WORD_W = 32,
    parameter int NARROW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wide,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              fin,
    output logic [WORD_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] tx_sr;
    logic [CNT_W-1:0]  bits_left;
    logic              running;
    logic              high_half;

    assign mosi = tx_sr[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr     <= '0;
            rx_word   <= '0;
            bits_left <= '0;
            running   <= 1'b0;
            high_half <= 1'b0;
            sclk      <= 1'b0;
            fin       <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                tx_sr     <= tx_word;
                rx_word   <= '0;
                bits_left <= wide ? CNT_W'(WORD_W) : CNT_W'(NARROW);
                running   <= 1'b1;
                high_half <= 1'b0;
            end else if (running) begin
                if (!high_half) begin
                    sclk      <= 1'b1;
                    rx_word   <= {rx_word[WORD_W-2:0], miso};
                    high_half <= 1'b1;
                end else begin
                    sclk      <= 1'b0;
                    tx_sr     <= {tx_sr[WORD_W-2:0], 1'b0};
                    high_half <= 1'b0;
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == CNT_W'(1)) begin
                        running <= 1'b0;
                        fin     <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_rd_count.sv
// Tracks bytes left in the read, bytes left in the current chunk, and the pause timer.
module spi_rd_count #(
    parameter int LEN_W     = 20,
    parameter int CHUNK_MAX = 65532,
    parameter int GAP_CYC   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             wide_in,
    input  logic             beat,
    input  logic             chunk_open,
    input  logic             gap_load,
    output logic             none_left,
    output logic             last_beat,
    output logic             chunk_last,
    output logic             gap_zero
);
    localparam int CW = $clog2(CHUNK_MAX + 1);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [LEN_W-1:0] remain;
    logic [CW-1:0]    chunk_left;
    logic [GW-1:0]    gap_cnt;
    logic             wide_q;
    logic [LEN_W-1:0] step_len;
    logic [CW-1:0]    step_chunk;

    assign step_len   = wide_q ? LEN_W'(4) : LEN_W'(1);
    assign step_chunk = wide_q ? CW'(4)    : CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain     <= '0;
            chunk_left <= '0;
            wide_q     <= 1'b0;
        end else if (load) begin
            remain     <= len_in;
            chunk_left <= '0;
            wide_q     <= wide_in;
        end else if (beat) begin
            remain     <= remain - step_len;
            chunk_left <= chunk_left - step_chunk;
        end else if (chunk_open) begin
            if (32'(remain) > 32'(CHUNK_MAX))
                chunk_left <= CW'(CHUNK_MAX);
            else
                chunk_left <= CW'(remain);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (gap_load)
            gap_cnt <= GW'(GAP_CYC - 1);
        else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - 1'b1;
    end

    assign none_left  = (remain == '0);
    assign last_beat  = (remain == step_len);
    assign chunk_last = (chunk_left == step_chunk);
    assign gap_zero   = (gap_cnt == '0);

endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
    import spi_rd_pkg::*;
#(
    parameter int LEN_W     = 20,
    parameter int CHUNK_MAX = 65532,
    parameter int GAP_CYC   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      addr,
    input  logic [LEN_W-1:0] len,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    output logic             rd_wide,
    output logic             done,
    output logic             err
);
    seq_state_t state, state_nx;

    logic                 addr_bad;
    logic                 req_ok;
    logic [ADDR_BITS-1:0] addr_q;
    logic                 wide_sel;

    logic                 sh_go;
    logic                 sh_wide;
    logic [BEAT_BITS-1:0] sh_tx;
    logic                 sh_fin;
    logic [BEAT_BITS-1:0] sh_rx;

    logic                 cnt_load;
    logic                 cnt_beat;
    logic                 cnt_open;
    logic                 cnt_gap;
    logic                 none_left;
    logic                 last_beat;
    logic                 chunk_last;
    logic                 gap_zero;

    assign addr_bad = |addr[31:ADDR_BITS];
    assign wide_sel = (len[1:0] == 2'b00);
    assign req_ok   = (state == ST_IDLE) && start && !addr_bad;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next state and control strobes
    always_comb begin
        state_nx = state;
        sh_go    = 1'b0;
        sh_wide  = rd_wide;
        sh_tx    = '0;
        cnt_load = 1'b0;
        cnt_beat = 1'b0;
        cnt_open = 1'b0;
        cnt_gap  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_ok) begin
                    cnt_load = 1'b1;
                    state_nx = ST_CMD_GO;
                end
            end
            ST_CMD_GO: begin
                sh_go    = 1'b1;
                sh_wide  = 1'b1;
                sh_tx    = {RD_OPCODE, addr_q};
                state_nx = ST_CMD_WAIT;
            end
            ST_CMD_WAIT: begin
                if (sh_fin) begin
                    if (none_left) begin
                        state_nx = ST_FINISH;
                    end else begin
                        cnt_open = 1'b1;
                        state_nx = ST_DATA_GO;
                    end
                end
            end
            ST_DATA_GO: begin
                sh_go    = 1'b1;
                state_nx = ST_DATA_WAIT;
            end
            ST_DATA_WAIT: begin
                if (sh_fin) begin
                    cnt_beat = 1'b1;
                    if (last_beat) begin
                        state_nx = ST_FINISH;
                    end else if (chunk_last) begin
                        cnt_gap  = 1'b1;
                        state_nx = ST_GAP;
                    end else begin
                        state_nx = ST_DATA_GO;
                    end
                end
            end
            ST_GAP: begin
                if (gap_zero) begin
                    cnt_open = 1'b1;
                    state_nx = ST_DATA_GO;
                end
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_cs_n <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_wide  <= 1'b0;
            addr_q   <= '0;
        end else begin
            done     <= 1'b0;
            err      <= 1'b0;
            rd_valid <= 1'b0;
            if (state == ST_IDLE && start) begin
                if (addr_bad) begin
                    err  <= 1'b1;
                    done <= 1'b1;
                end else begin
                    spi_cs_n <= 1'b0;
                    rd_wide  <= wide_sel;
                    addr_q   <= addr[ADDR_BITS-1:0];
                end
            end
            if (state == ST_DATA_WAIT && sh_fin) begin
                rd_valid <= 1'b1;
                rd_data  <= sh_rx;
            end
            if (state == ST_FINISH) begin
                spi_cs_n <= 1'b1;
                done     <= 1'b1;
            end
        end
    end

    spi_rd_shift #(
        .WORD_W (BEAT_BITS),
        .NARROW (BYTE_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .wide    (sh_wide),
        .tx_word (sh_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .fin     (sh_fin),
        .rx_word (sh_rx)
    );

    spi_rd_count #(
        .LEN_W     (LEN_W),
        .CHUNK_MAX (CHUNK_MAX),
        .GAP_CYC   (GAP_CYC)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .len_in     (len),
        .wide_in    (wide_sel),
        .beat       (cnt_beat),
        .chunk_open (cnt_open),
        .gap_load   (cnt_gap),
        .none_left  (none_left),
        .last_beat  (last_beat),
        .chunk_last (chunk_last),
        .gap_zero   (gap_zero)
    );

endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic rd_valid,
    input logic done,
    input logic err
);
    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R3
    err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (spi_cs_n && $past(spi_cs_n)));

    // R3
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R8
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done);

    // R5
    beat_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n);

endmodule

bind spi_flash_rd spi_flash_rd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .rd_valid (rd_valid),
    .done     (done),
    .err      (err)
);

// File: tb/spi_flash_rd_bench.sv
module spi_flash_rd_bench;
    localparam int LEN_W = 12;
    localparam int CHUNK = 8;
    localparam int GAPC  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [31:0]      addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic             spi_cs_n, spi_sclk, spi_mosi;
    logic             spi_miso = 1'b0;
    logic [31:0]      rd_data;
    logic             rd_valid, rd_wide, done, err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    spi_flash_rd #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK), .GAP_CYC(GAPC)) u_spi_flash_rd (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .len(len),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_wide(rd_wide), .done(done), .err(err)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C ^ {a[3:0], a[7:4]};
    endfunction

    // Flash model: captures command, then drives data bits after each falling edge
    int          fbits = 0;
    logic [31:0] fcmd  = '0;
    always @(negedge spi_cs_n) fbits = 0;
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        if (fbits < 32) fcmd = {fcmd[30:0], spi_mosi};
        fbits++;
    end
    always @(negedge spi_sclk) if (!spi_cs_n && fbits >= 32) begin
        int off;
        logic [7:0] b;
        off = fbits - 32;
        b = mem_byte({8'h00, fcmd[23:0]} + 32'(off / 8));
        spi_miso = b[7 - (off % 8)];
    end

    // Port monitor
    logic [31:0] beats [64];
    int  nbeats, gaps, run, rises, cs_falls, cs_rises, done_seen, err_seen;
    int  done_cs_rise;
    bit  seen_rise, prev_cs, prev_sclk;
    always @(negedge clk) begin
        if (rd_valid) begin
            if (nbeats < 64) beats[nbeats] = rd_data;
            nbeats++;
        end
        if (done) done_seen++;
        if (err) err_seen++;
        if (spi_sclk && !prev_sclk) begin
            rises++;
            if (seen_rise && run >= GAPC - 2) gaps++;
            run = 0;
            seen_rise = 1;
        end else if (!spi_cs_n && !spi_sclk) begin
            run++;
        end
        if (!spi_cs_n && prev_cs) cs_falls++;
        if (spi_cs_n && !prev_cs) begin
            cs_rises++;
            if (done) done_cs_rise++;
        end
        prev_cs   = spi_cs_n;
        prev_sclk = spi_sclk;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nbeats = 0; gaps = 0; run = 0; rises = 0; cs_falls = 0; cs_rises = 0;
        done_seen = 0; err_seen = 0; done_cs_rise = 0; seen_rise = 0;
        fcmd = '0;
    endtask

    // Issues one read; poke > 0 sends a second start that many cycles later
    task automatic do_read(input logic [31:0] a, input int n, input int poke);
        int wait_c;
        @(negedge clk);
        clear_mon();
        addr = a; len = LEN_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_c = 1;
        while (done_seen == 0 && wait_c < 5000) begin
            if (poke > 0 && wait_c == poke) begin
                addr = 32'h0000_0777; len = LEN_W'(40); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            wait_c++;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_good(input string req, input logic [31:0] a, input int n);
        bit wide_exp;
        int exp_beats, exp_gaps, nchunk;
        bit data_ok;
        logic [31:0] exp_w, bad_w, bad_e;
        wide_exp  = (n % 4 == 0);
        exp_beats = wide_exp ? n / 4 : n;
        nchunk    = (n + CHUNK - 1) / CHUNK;
        exp_gaps  = (nchunk > 0) ? nchunk - 1 : 0;
        chk(done_seen == 1 && err_seen == 0, req, "done once, no err", 32'(done_seen), 1);
        // R2 command word
        chk(fcmd == {8'h03, a[23:0]}, "R2", "command word", fcmd, {8'h03, a[23:0]});
        // R4 clock count
        chk(rises == 32 + 8 * n, "R4", "sclk rising edges", 32'(rises), 32'(32 + 8 * n));
        chk(nbeats == exp_beats, req, "beat count", 32'(nbeats), 32'(exp_beats));
        if (n != 0)
            chk(rd_wide == wide_exp, req, "beat width flag", 32'(rd_wide), 32'(wide_exp));
        data_ok = 1; bad_w = '0; bad_e = '0;
        for (int i = 0; i < exp_beats && i < 64; i++) begin
            if (wide_exp)
                exp_w = {mem_byte(a + 32'(4*i)), mem_byte(a + 32'(4*i+1)),
                         mem_byte(a + 32'(4*i+2)), mem_byte(a + 32'(4*i+3))};
            else
                exp_w = {24'h0, mem_byte(a + 32'(i))};
            if (data_ok && beats[i] !== exp_w) begin
                data_ok = 0; bad_w = beats[i]; bad_e = exp_w;
            end
        end
        chk(data_ok, req, "beat data", bad_w, bad_e);
        // R7 chunk pauses
        chk(gaps == exp_gaps, "R7", "chunk pauses", 32'(gaps), 32'(exp_gaps));
        // R8 one frame, release together with done
        chk(cs_falls == 1 && cs_rises == 1, "R8", "cs edges", 32'(cs_falls + cs_rises), 2);
        chk(done_cs_rise == 1, "R8", "cs release with done", 32'(done_cs_rise), 1);
    endtask

    task automatic t_reset();
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "bus idle after reset",
            {30'h0, spi_cs_n, spi_sclk}, 32'h2);
        chk(done === 1'b0 && err === 1'b0 && rd_valid === 1'b0, "R1", "flags after reset",
            {29'h0, done, err, rd_valid}, 0);
    endtask

    task automatic t_word_short();
        do_read(32'h0000_1234, 8, 0);
        check_good("R5", 32'h0000_1234, 8);
    endtask

    task automatic t_byte_short();
        do_read(32'h00AB_CDEF, 5, 0);
        check_good("R6", 32'h00AB_CDEF, 5);
    endtask

    task automatic t_word_long();
        do_read(32'h0002_0010, 20, 0);
        check_good("R7", 32'h0002_0010, 20);
    endtask

    task automatic t_exact_chunks();
        do_read(32'h00FF_FFF0, 16, 0);
        check_good("R7", 32'h00FF_FFF0, 16);
    endtask

    task automatic t_byte_long();
        do_read(32'h0040_0003, 19, 0);
        check_good("R6", 32'h0040_0003, 19);
    endtask

    task automatic t_bad_addr();
        do_read(32'h0100_0000, 8, 0);
        chk(err_seen == 1 && done_seen == 1, "R3", "err and done pulse",
            32'(err_seen * 16 + done_seen), 32'h11);
        chk(cs_falls == 0 && rises == 0, "R3", "no bus activity", 32'(cs_falls + rises), 0);
        chk(nbeats == 0, "R3", "no beats", 32'(nbeats), 0);
    endtask

    task automatic t_zero_len();
        do_read(32'h0000_5000, 0, 0);
        check_good("R9", 32'h0000_5000, 0);
    endtask

    task automatic t_busy_start();
        do_read(32'h0000_0100, 8, 20);
        check_good("R10", 32'h0000_0100, 8);
        chk(cs_falls == 1, "R10", "single frame despite second start", 32'(cs_falls), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_word_short();
        t_byte_short();
        t_word_long();
        t_exact_chunks();
        t_byte_long();
        t_bad_addr();
        t_zero_len();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule